// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Aligner with Automatic Interworking

This block sits behind an E1 basic frame aligner. On every received frame it gets a strobe, the frame's index within the receiver's 16-frame count, and the first bit of the frame's timeslot 0. It only works while the basic aligner reports alignment. It looks for the six-bit CRC-4 multiframe word in the non-alignment frames, confirms it once, and then declares CRC-4 multiframe sync together with the multiframe phase it found.

While the search runs, the block tells the basic aligner to keep its primary alignment frozen. When the search ends, the block publishes the multiframe phase so that the receiver can adopt it. With automatic interworking enabled (active-low control), a search that has not succeeded within a frame-count timeout marks the far end as non-CRC-4. From then on, receive CRC-4 checking stays off and the transmitted E-bits are forced to zero. In CRC-to-CRC operation, the E-bits report the received CRC block check results one sub-multiframe at a time.

Top module: `crc4_mf_aligner`

## Requirements
- R1: While `basic_aligned` is low, the search state, the word history and the timeout count are cleared: `crc_sync_n`=1, `far_noncrc`=0, `rx_crc_en`=0, `prim_hold`=0.
- R2: Only frames with odd `frm_idx` are non-alignment frames, and their `si_bit` is the one sampled. The alignment word is 0,0,1,0,1,1 in arrival order (oldest first). A match needs six such samples taken since alignment.
- R3: A first match makes a candidate. If the eighth non-alignment frame after it also completes a match, `crc_sync_n` goes to 0 and `rx_crc_en` goes to 1 on the clock edge that samples that frame. Sync then holds until alignment is lost.
- R4: If that eighth non-alignment frame does not complete a match, the candidate is dropped. Sync then needs a fresh pair of matches.
- R5: With `autoint_n`=0, sync not reached, and the strobe being the TIMEOUT_FRAMES-th or a later frame since alignment, the block enters non-CRC-4 mode: `far_noncrc`=1, `rx_crc_en`=0, until alignment is lost. A confirming match on that same strobe wins over the timeout. A first match does not.
- R6: With `autoint_n`=1 the block never enters non-CRC-4 mode and keeps searching.
- R7: In non-CRC-4 mode `tx_ebit` is 2'b00 whatever the other inputs are.
- R8: While not in sync and not in non-CRC-4 mode, `tx_ebit` is 2'b00 when `ebit_hold`=1 and 2'b11 when `ebit_hold`=0.
- R9: In sync, both E-bits start at 1. A `chk_vld` pulse sets bit `chk_smf` (0 or 1) to the inverse of `chk_bad` from the next cycle on. Reports outside sync have no effect.
- R10: `prim_hold` is 1 exactly while `basic_aligned`=1 and the block is neither in sync nor in non-CRC-4 mode.
- R11: In sync, `mf_phase` equals (`frm_idx` of the confirming frame + 5) mod 16. This is the receiver index that multiframe frame 0 lands on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_stb | input | 1 | One-cycle pulse per received frame |
| frm_idx | input | 4 | Receiver frame index, odd = non-alignment frame |
| si_bit | input | 1 | First bit of timeslot 0 for this frame |
| basic_aligned | input | 1 | Basic frame alignment present |
| autoint_n | input | 1 | Automatic interworking enable, active low |
| ebit_hold | input | 1 | Force E-bits to zero until the interworking outcome is known |
| chk_vld | input | 1 | Received CRC block check result valid |
| chk_bad | input | 1 | Received CRC block check failed |
| chk_smf | input | 1 | Sub-multiframe the check result belongs to |
| crc_sync_n | output | 1 | CRC-4 multiframe sync, active low |
| far_noncrc | output | 1 | Far end judged non-CRC-4 |
| rx_crc_en | output | 1 | Receive CRC-4 processing enable |
| prim_hold | output | 1 | Freeze primary basic alignment updates |
| mf_phase | output | 4 | Adopted multiframe phase, valid in sync |
| tx_ebit | output | 2 | E-bits for transmission, bit i for sub-multiframe i |

## Verification
The bench builds the aligner with TIMEOUT_FRAMES set to 40 instead of the 3200 used by default. With a frame strobe every second clock, the timeout is then reached in about 80 clocks. This makes it practical to run every scenario: a clean two-word lock ahead of the timeout, a broken second word that is followed by a lock after the timeout has passed with interworking disabled, a fall-back with no words at all, and the late enabling of interworking after the timeout has expired. It also puts the race between the confirming word and the timeout within a few frames of each other.

// File: rtl/crc4mf_pkg.sv
package crc4mf_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNC    = 2'd2,
    ST_NONCRC  = 2'd3
  } mfa_state_e;

  localparam int unsigned MFAS_LEN    = 6;
  localparam logic [MFAS_LEN-1:0] MFAS_WORD = 6'b001011;
  localparam int unsigned NFAS_PER_MF = 8;
  localparam int unsigned MF_FRAMES   = 16;
  localparam int unsigned IDX_W       = $clog2(MF_FRAMES);
  localparam logic [IDX_W-1:0] WORD_END_FRAME = 4'd11;
  localparam int unsigned NSMF        = 2;
  localparam int unsigned SMF_W       = $clog2(NSMF);

endpackage

// File: rtl/mfas_detect.sv
module mfas_detect #(
  parameter int unsigned WLEN = 6,
  parameter logic [WLEN-1:0] WORD = 6'b001011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic nfas_stb,
  input  logic si_bit,
  output logic word_hit
);
  localparam int unsigned FW = $clog2(WLEN);
  localparam logic [FW-1:0] FULL = FW'(WLEN - 1);

  logic [WLEN-2:0] hist_q, hist_d;
  logic [FW-1:0]   fill_q, fill_d;

  always_comb begin
    hist_d = hist_q;
    fill_d = fill_q;
    if (clr) begin
      hist_d = '0;
      fill_d = '0;
    end else if (nfas_stb) begin
      hist_d = {hist_q[WLEN-3:0], si_bit};
      if (fill_q != FULL) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  assign word_hit = nfas_stb && !clr && (fill_q == FULL) && ({hist_q, si_bit} == WORD);

  // R2
  fill_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_q == '0));

endmodule

// File: rtl/iw_timer.sv
module iw_timer #(
  parameter int unsigned LIMIT = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expire_now
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (tick && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_now = tick && !clr && (cnt_q == LAST);

  // R5
  tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R5
  tmr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST && !clr) |=> (cnt_q == LAST));

endmodule

// File: rtl/ebit_gen.sv
module ebit_gen
  import crc4mf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_sync,
  input  logic             noncrc,
  input  logic             hold_zero,
  input  logic             chk_vld,
  input  logic             chk_bad,
  input  logic [SMF_W-1:0] chk_smf,
  output logic [NSMF-1:0]  tx_ebit
);
  logic [NSMF-1:0] e_q, e_d;

  for (genvar i = 0; i < NSMF; i++) begin : g_ebit
    assign e_d[i] = !in_sync ? 1'b1 :
                    (chk_vld && (chk_smf == SMF_W'(i))) ? ~chk_bad : e_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_q <= '1;
    else        e_q <= e_d;
  end

  always_comb begin
    if (noncrc)         tx_ebit = '0;
    else if (in_sync)   tx_ebit = e_q;
    else if (hold_zero) tx_ebit = '0;
    else                tx_ebit = '1;
  end

  // R9
  ebit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && $past(in_sync) && !$stable(e_q)) |-> $past(chk_vld));

endmodule

// File: rtl/crc4_mf_aligner.sv
module crc4_mf_aligner
  import crc4mf_pkg::*;
#(
  parameter int unsigned TIMEOUT_FRAMES = 3200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_stb,
  input  logic [3:0] frm_idx,
  input  logic       si_bit,
  input  logic       basic_aligned,
  input  logic       autoint_n,
  input  logic       ebit_hold,
  input  logic       chk_vld,
  input  logic       chk_bad,
  input  logic       chk_smf,
  output logic       crc_sync_n,
  output logic       far_noncrc,
  output logic       rx_crc_en,
  output logic       prim_hold,
  output logic [3:0] mf_phase,
  output logic [1:0] tx_ebit
);
  localparam int unsigned NFW = $clog2(NFAS_PER_MF);
  localparam logic [NFW-1:0] NF_LAST = NFW'(NFAS_PER_MF - 1);

  mfa_state_e     st_q, st_d;
  logic [NFW-1:0] nf_q, nf_d;
  logic [3:0]     ph_q, ph_d;

  logic clr, nfas_stb, word_hit, tmo_now, confirm_slot, fallback;

  assign clr      = !basic_aligned;
  assign nfas_stb = frm_stb && basic_aligned && frm_idx[0];

  mfas_detect #(
    .WLEN (MFAS_LEN),
    .WORD (MFAS_WORD)
  ) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .nfas_stb (nfas_stb),
    .si_bit   (si_bit),
    .word_hit (word_hit)
  );

  iw_timer #(
    .LIMIT (TIMEOUT_FRAMES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .tick       (frm_stb),
    .expire_now (tmo_now)
  );

  assign confirm_slot = nfas_stb && (nf_q == NF_LAST);
  assign fallback     = tmo_now && !autoint_n;

  always_comb begin
    st_d = st_q;
    nf_d = nf_q;
    ph_d = ph_q;
    if (!basic_aligned) begin
      st_d = ST_HUNT;
      nf_d = '0;
    end else if (frm_stb) begin
      case (st_q)
        ST_HUNT: begin
          if (fallback) begin
            st_d = ST_NONCRC;
          end else if (word_hit) begin
            st_d = ST_CONFIRM;
            nf_d = '0;
          end
        end
        ST_CONFIRM: begin
          if (confirm_slot && word_hit) begin
            st_d = ST_SYNC;
            ph_d = frm_idx - WORD_END_FRAME;
          end else if (fallback) begin
            st_d = ST_NONCRC;
          end else if (confirm_slot) begin
            st_d = ST_HUNT;
          end else if (nfas_stb) begin
            nf_d = nf_q + 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HUNT;
      nf_q <= '0;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      nf_q <= nf_d;
      ph_q <= ph_d;
    end
  end

  ebit_gen u_ebit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_sync   (st_q == ST_SYNC),
    .noncrc    (st_q == ST_NONCRC),
    .hold_zero (ebit_hold),
    .chk_vld   (chk_vld),
    .chk_bad   (chk_bad),
    .chk_smf   (chk_smf),
    .tx_ebit   (tx_ebit)
  );

  assign crc_sync_n = (st_q != ST_SYNC);
  assign rx_crc_en  = (st_q == ST_SYNC);
  assign far_noncrc = (st_q == ST_NONCRC);
  assign prim_hold  = basic_aligned && (st_q == ST_HUNT || st_q == ST_CONFIRM);
  assign mf_phase   = ph_q;

  // R3
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SYNC && $past(st_q) != ST_SYNC) |-> $past(word_hit && st_q == ST_CONFIRM));

  // R5
  noncrc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NONCRC && $past(st_q) != ST_NONCRC) |-> $past(!autoint_n && tmo_now));

  // R1
  realign_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !basic_aligned |=> (st_q == ST_HUNT));

  // R11
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SYNC && $past(st_q) == ST_SYNC) |-> $stable(ph_q));

endmodule

// File: tb/crc4_mf_aligner_tb.sv
`timescale 1ns/1ps
module crc4_mf_aligner_tb_top;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic frm_stb, si_bit, basic_aligned, autoint_n, ebit_hold;
  logic chk_vld, chk_bad, chk_smf;
  logic [3:0] frm_idx;
  logic crc_sync_n, far_noncrc, rx_crc_en, prim_hold;
  logic [3:0] mf_phase;
  logic [1:0] tx_ebit;

  always #2 clk = ~clk;

  crc4_mf_aligner #(.TIMEOUT_FRAMES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_idx(frm_idx), .si_bit(si_bit),
    .basic_aligned(basic_aligned), .autoint_n(autoint_n), .ebit_hold(ebit_hold),
    .chk_vld(chk_vld), .chk_bad(chk_bad), .chk_smf(chk_smf),
    .crc_sync_n(crc_sync_n), .far_noncrc(far_noncrc), .rx_crc_en(rx_crc_en),
    .prim_hold(prim_hold), .mf_phase(mf_phase), .tx_ebit(tx_ebit)
  );

  int total = 0;
  int bad = 0;
  int bidx = 0;
  bit done = 0;
  bit run = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  int q[$];
  int m_st = 0, m_nf = 0, m_tc = 0, m_ph = 0, m_e0 = 1, m_e1 = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_nf = 0; m_tc = 0; m_ph = 0; m_e0 = 1; m_e1 = 1; q.delete();
    end else begin
      int old;
      bit tmo, nfas, hit;
      old = m_st;
      if (old != 2) begin m_e0 = 1; m_e1 = 1; end
      else if (chk_vld) begin
        if (chk_smf) m_e1 = !chk_bad; else m_e0 = !chk_bad;
      end
      if (!basic_aligned) begin
        m_st = 0; m_nf = 0; m_tc = 0; q.delete();
      end else if (frm_stb) begin
        tmo = (m_tc >= T - 1);
        if (m_tc < T - 1) m_tc++;
        nfas = frm_idx[0];
        hit = 0;
        if (nfas) begin
          q.push_back(int'(si_bit));
          if (q.size() > 6) void'(q.pop_front());
          hit = (q.size() == 6) && q[0] == 0 && q[1] == 0 && q[2] == 1 &&
                q[3] == 0 && q[4] == 1 && q[5] == 1;
        end
        if (m_st == 0) begin
          if (tmo && !autoint_n) m_st = 3;
          else if (hit) begin m_st = 1; m_nf = 0; end
        end else if (m_st == 1) begin
          if (nfas) m_nf++;
          if (nfas && m_nf == 8 && hit) begin m_st = 2; m_ph = (int'(frm_idx) + 5) % 16; end
          else if (tmo && !autoint_n) m_st = 3;
          else if (nfas && m_nf == 8) m_st = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      int exp_e;
      exp_e = (m_st == 3) ? 0 : (m_st == 2) ? (m_e1 * 2 + m_e0) : (ebit_hold ? 0 : 3);
      chk("R3", "crc_sync_n", int'(crc_sync_n), (m_st == 2) ? 0 : 1);
      chk("R3", "rx_crc_en", int'(rx_crc_en), (m_st == 2) ? 1 : 0);
      chk("R5", "far_noncrc", int'(far_noncrc), (m_st == 3) ? 1 : 0);
      chk("R10", "prim_hold", int'(prim_hold), (basic_aligned && m_st < 2) ? 1 : 0);
      chk("R9", "tx_ebit", int'(tx_ebit), exp_e);
      if (m_st == 2) chk("R11", "mf_phase", int'(mf_phase), m_ph);
    end
  end

  function automatic logic si_for(input int idx, input bit corrupt);
    int f, k;
    logic b;
    f = (idx + 12) % 16;
    if (f % 2 == 0) return 1'b1;
    k = (f - 1) / 2;
    if (k >= 6) return 1'b1;
    b = 1'((6'b001011 >> (5 - k)) & 1);
    if (corrupt && k == 2) b = ~b;
    return b;
  endfunction

  task automatic send_frames(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      frm_stb = 1'b1;
      frm_idx = 4'(bidx);
      si_bit  = (mode == 2) ? 1'b1 : si_for(bidx, mode == 1);
      @(negedge clk); #1;
      frm_stb = 1'b0;
      bidx = (bidx + 1) % 16;
    end
  endtask

  task automatic crc_report(input logic smf, input logic failed);
    @(negedge clk); #1;
    chk_vld = 1'b1; chk_smf = smf; chk_bad = failed;
    @(negedge clk); #1;
    chk_vld = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic drop_align;
    @(negedge clk); #1;
    basic_aligned = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "crc_sync_n unaligned", int'(crc_sync_n), 1);
    chk("R1", "far_noncrc unaligned", int'(far_noncrc), 0);
    chk("R1", "rx_crc_en unaligned", int'(rx_crc_en), 0);
    chk("R10", "prim_hold unaligned", int'(prim_hold), 0);
    basic_aligned = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frm_stb = 1'b0; frm_idx = '0; si_bit = 1'b0;
    basic_aligned = 1'b0; autoint_n = 1'b0; ebit_hold = 1'b0;
    chk_vld = 1'b0; chk_bad = 1'b0; chk_smf = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset crc_sync_n", int'(crc_sync_n), 1);
    chk("R1", "reset far_noncrc", int'(far_noncrc), 0);
    chk("R1", "reset rx_crc_en", int'(rx_crc_en), 0);
    chk("R8", "reset tx_ebit", int'(tx_ebit), 3);
    rst_n = 1'b1;
    run = 1'b1;

    // A: clean lock, hold-zero E-bits, interworking on
    basic_aligned = 1'b1; ebit_hold = 1'b1;
    send_frames(31, 0);
    chk("R2", "no sync before second word", int'(crc_sync_n), 1);
    chk("R8", "held E-bits during search", int'(tx_ebit), 0);
    chk("R10", "prim_hold during search", int'(prim_hold), 1);
    send_frames(1, 0);
    chk("R3", "sync after second word", int'(crc_sync_n), 0);
    chk("R11", "mf_phase", int'(mf_phase), 4);
    chk("R9", "E-bits on sync entry", int'(tx_ebit), 3);
    crc_report(1'b1, 1'b1);
    chk("R9", "E-bit smf1 errored", int'(tx_ebit), 1);
    crc_report(1'b0, 1'b0);
    chk("R9", "E-bit smf0 clean", int'(tx_ebit), 1);
    crc_report(1'b1, 1'b0);
    chk("R9", "E-bit smf1 clean", int'(tx_ebit), 3);
    send_frames(20, 0);
    chk("R5", "sync survives past timeout", int'(far_noncrc), 0);

    // B: broken second word, interworking off
    drop_align();
    ebit_hold = 1'b0; autoint_n = 1'b1;
    @(negedge clk); #1;
    chk("R8", "E-bits ones during search", int'(tx_ebit), 3);
    send_frames(16, 0);
    send_frames(16, 1);
    chk("R4", "restart after bad word", int'(crc_sync_n), 1);
    chk("R4", "prim_hold after restart", int'(prim_hold), 1);
    send_frames(16, 0);
    chk("R6", "no fallback when disabled", int'(far_noncrc), 0);
    chk("R4", "single word after restart", int'(crc_sync_n), 1);
    send_frames(16, 0);
    chk("R4", "sync after fresh pair", int'(crc_sync_n), 0);

    // C: no words, fallback to non-CRC-4
    drop_align();
    autoint_n = 1'b0; ebit_hold = 1'b1;
    send_frames(T - 1, 2);
    chk("R5", "no fallback before timeout", int'(far_noncrc), 0);
    send_frames(1, 2);
    chk("R5", "fallback at timeout", int'(far_noncrc), 1);
    chk("R5", "rx crc off", int'(rx_crc_en), 0);
    ebit_hold = 1'b0;
    @(negedge clk); #1;
    chk("R7", "E-bits zero non-CRC", int'(tx_ebit), 0);
    crc_report(1'b0, 1'b0);
    chk("R9", "report ignored non-CRC", int'(tx_ebit), 0);
    send_frames(32, 0);
    chk("R5", "non-CRC sticky", int'(far_noncrc), 1);
    chk("R7", "E-bits still zero", int'(tx_ebit), 0);

    // D: timeout passes while disabled, then enabled
    drop_align();
    autoint_n = 1'b1;
    send_frames(T + 5, 2);
    chk("R6", "disabled past timeout", int'(far_noncrc), 0);
    chk("R8", "E-bits ones unheld", int'(tx_ebit), 3);
    autoint_n = 1'b0;
    send_frames(1, 2);
    chk("R5", "fallback once enabled", int'(far_noncrc), 1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule